// File: doc/BRIEF.md
# Analog Output Sample Sequencer

This block sits between a host write path and one or two digital-to-analog converter channels. The host delivers 32-bit words. Each word packs two 16-bit offset-binary samples, and both samples go into a shared sample store. While the sequencer is armed, each pulse of a pacing enable takes exactly one sample from the store. The sample goes to a registered channel output, which raises a one-cycle strobe. A channel setting picks either one converter, which takes every sample in order, or two converters, where even-numbered samples go to channel 0 and odd-numbered samples go to channel 1.

The block has two operating modes. In streamed mode, each sample is used once. A pacing tick that finds the store empty sets a sticky underrun flag, and the outputs keep their last values. In waveform mode, the store is filled while the sequencer is idle. After the sequencer is armed, the stored samples are replayed in an endless loop, and further host words are refused. A stop input returns the block to idle and discards all stored samples.

Top module: `aout_seq`

## Requirements
- R1: Bits [15:0] of a host word are the even sample and bits [31:16] are the odd sample. The even sample enters the store first and is played first.
- R2: A word is stored only in a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low whenever the store has fewer than two free sample entries. With the default depth of 32, that means 16 stored words fill the store.
- R3: `start` in idle makes `active` high after the next clock edge. `stop` makes `active` low and empties the store after the next clock edge. When both arrive in the same cycle, `stop` wins.
- R4: While `active` is high, each `pace` pulse takes exactly one sample from the store. While the block is idle, `pace` has no effect on the outputs or on the stored data.
- R5: With `cfg_dual`=1, samples taken in even order (the first, third, and so on after `start`) go to channel 0, and samples taken in odd order go to channel 1.
- R6: With `cfg_dual`=0, every sample goes to channel 0 in store order, and channel 1 never strobes.
- R7: In streamed mode (`cfg_wave`=0), each sample is used once. A `pace` pulse while active with an empty store sets `underrun`, and no strobe follows. `underrun` stays high until the next `start`.
- R8: In waveform mode (`cfg_wave`=1), replay runs from the first stored sample to the last stored sample and then wraps back to the first, for as long as the block stays active.
- R9: In waveform mode, while the block is active, `wr_ready` is low and the stored samples do not change.
- R10: A sample taken on a `pace` edge shows up on its channel data output after that edge, with a strobe that lasts exactly one cycle. Without a strobe, channel data holds its value. After reset, both channels hold mid-scale 0x8000, both strobes are low, `active` is low, and `underrun` is low.
- R11: `cfg_wave` and `cfg_dual` are sampled when `start` is accepted. Changing them while the block is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wave | input | 1 | Mode select, sampled at start: 1 selects waveform replay, 0 selects streamed |
| cfg_dual | input | 1 | Channel select, sampled at start: 1 selects two converters, 0 selects one |
| start | input | 1 | Arms the sequencer from idle |
| stop | input | 1 | Halts the sequencer and empties the store |
| wr_valid | input | 1 | Host word present |
| wr_data | input | 32 | Host word: odd sample in [31:16], even sample in [15:0] |
| wr_ready | output | 1 | Store can take a word this cycle |
| pace | input | 1 | Pacing enable, one sample per high cycle |
| dac0_data | output | 16 | Channel 0 sample code |
| dac0_strb | output | 1 | Channel 0 new-sample strobe |
| dac1_data | output | 16 | Channel 1 sample code |
| dac1_strb | output | 1 | Channel 1 new-sample strobe |
| underrun | output | 1 | Sticky flag for a pacing tick that found the store empty |
| active | output | 1 | Sequencer is armed |

## Verification
Some properties are checked by assertions on every cycle:
- every strobe is traced back to a pacing tick taken while active;
- channel data holds when there is no strobe;
- the underrun flag stays set until the next start;
- the store never fills past its depth;
- stop empties the store;
- a waveform replay never changes the stored sample count;
- channel 1 stays silent in single-channel mode.

Other behaviour needs the bench scenarios: the actual sample values and their order, the even/odd split across channels, the wrap point of the replay loop, and the fact that configuration changes made mid-run are ignored. A behavioural queue model checks these cycle by cycle.

// File: rtl/aout_pkg.sv
// Shared types and helpers for the analog output sequencer.
// Assumes: sample codes are offset binary, so mid-scale is the MSB alone.
package aout_pkg;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } seq_state_t;

    // Mid-scale code for a given sample width.
    function automatic logic [31:0] midscale(input int w);
        return 32'd1 << (w - 1);
    endfunction

endpackage

// File: rtl/aout_store.sv
// Circular sample store. Each push writes two samples: the low half of the
// word first, then the high half. A stream pop consumes the head. A wave pop
// only advances the read pointer, and wraps to the marked base once it
// reaches the write pointer.
// Assumes: DEPTH is a power of two, at least 2; the caller never pushes
// unless two entries are free, and never pops an empty store.
module aout_store #(
    parameter int SW    = 16,
    parameter int DEPTH = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            push,
    input  logic [2*SW-1:0] push_word,
    input  logic            pop_stream,
    input  logic            pop_wave,
    input  logic            mark_base,
    output logic [SW-1:0]   head,
    output logic [CW-1:0]   fill
);

    logic [SW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] base_ptr;
    logic [PW-1:0] wr_nxt;
    logic [PW-1:0] rd_nxt;

    assign wr_nxt = wr_ptr + PW'(1);
    assign rd_nxt = rd_ptr + PW'(1);
    assign head   = mem[rd_ptr];

    // Sample array write: even sample at wr_ptr, odd sample right after it.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_word[SW-1:0];
            mem[wr_nxt] <= push_word[2*SW-1:SW];
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            base_ptr <= '0;
            fill     <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + PW'(2);
            end
            if (pop_stream) begin
                rd_ptr <= rd_nxt;
            end else if (pop_wave) begin
                rd_ptr <= (rd_nxt == wr_ptr) ? base_ptr : rd_nxt;
            end
            if (mark_base) begin
                base_ptr <= rd_ptr;
            end
            fill <= fill + (push ? CW'(2) : CW'(0)) - (pop_stream ? CW'(1) : CW'(0));
        end
    end

endmodule

// File: rtl/aout_route.sv
// Output channel registers. A fired sample is loaded into channel 1 when
// to_ch1 is set, and into channel 0 otherwise, with a one-cycle strobe.
// Assumes: fire lasts one cycle for each sample taken.
module aout_route #(
    parameter int SW = 16,
    localparam int NCH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic          to_ch1,
    input  logic [SW-1:0] sample,
    output logic [SW-1:0] ch_data [NCH],
    output logic [NCH-1:0] ch_strb
);

    localparam logic [SW-1:0] MID = SW'(aout_pkg::midscale(SW));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        assign sel = (c == 1) ? to_ch1 : !to_ch1;

        // Channel register: load on a selected fire, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_data[c] <= MID;
                ch_strb[c] <= 1'b0;
            end else begin
                ch_strb[c] <= fire && sel;
                if (fire && sel) begin
                    ch_data[c] <= sample;
                end
            end
        end
    end

endmodule

// File: rtl/aout_seq.sv
// Analog output sequencer top. Host words load a sample store. While the
// block is armed, each pace pulse takes one sample and routes it by take
// order to one or two channels. Streamed mode consumes the data; waveform
// mode replays the stored data in a loop and refuses new writes.
// Assumes: pace is a single-cycle enable from the converter clock domain,
// already synchronised to clk.
module aout_seq #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 32,
    localparam int CW      = $clog2(DEPTH) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wave,
    input  logic                  cfg_dual,
    input  logic                  start,
    input  logic                  stop,
    input  logic                  wr_valid,
    input  logic [2*SAMPLE_W-1:0] wr_data,
    output logic                  wr_ready,
    input  logic                  pace,
    output logic [SAMPLE_W-1:0]   dac0_data,
    output logic                  dac0_strb,
    output logic [SAMPLE_W-1:0]   dac1_data,
    output logic                  dac1_strb,
    output logic                  underrun,
    output logic                  active
);

    import aout_pkg::*;

    seq_state_t          state;
    logic                run_wave;
    logic                run_dual;
    logic                parity;
    logic                und_q;
    logic [CW-1:0]       fill;
    logic [SAMPLE_W-1:0] head;
    logic                tick_live;
    logic                fire;
    logic                starve;
    logic                push;
    logic                arm;
    logic [SAMPLE_W-1:0] ch_data [2];
    logic [1:0]          ch_strb;

    // Control decode for this cycle.
    always_comb begin
        tick_live = (state == S_RUN) && pace && !stop;
        fire      = tick_live && (fill != '0);
        starve    = tick_live && (fill == '0);
        arm       = (state == S_IDLE) && start && !stop;
        wr_ready  = !stop && ((state == S_IDLE) || !run_wave)
                    && (fill <= CW'(DEPTH - 2));
        push      = wr_valid && wr_ready;
    end

    // Sequencer state, latched configuration, take parity and underrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            run_wave <= 1'b0;
            run_dual <= 1'b0;
            parity   <= 1'b0;
            und_q    <= 1'b0;
        end else if (stop) begin
            state  <= S_IDLE;
            parity <= 1'b0;
        end else begin
            if (arm) begin
                state    <= S_RUN;
                run_wave <= cfg_wave;
                run_dual <= cfg_dual;
                parity   <= 1'b0;
                und_q    <= 1'b0;
            end
            if (fire) begin
                parity <= !parity;
            end
            if (starve) begin
                und_q <= 1'b1;
            end
        end
    end

    aout_store #(
        .SW    (SAMPLE_W),
        .DEPTH (DEPTH)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (stop),
        .push       (push),
        .push_word  (wr_data),
        .pop_stream (fire && !run_wave),
        .pop_wave   (fire && run_wave),
        .mark_base  (arm),
        .head       (head),
        .fill       (fill)
    );

    aout_route #(
        .SW (SAMPLE_W)
    ) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .to_ch1  (run_dual && parity),
        .sample  (head),
        .ch_data (ch_data),
        .ch_strb (ch_strb)
    );

    assign dac0_data = ch_data[0];
    assign dac1_data = ch_data[1];
    assign dac0_strb = ch_strb[0];
    assign dac1_strb = ch_strb[1];
    assign underrun  = und_q;
    assign active    = (state == S_RUN);

endmodule

// File: rtl/aout_seq_chk.sv
// Property checker for aout_seq, attached by bind below.
// Assumes: bound inside aout_seq so the internal fill and latched config are visible.
module aout_seq_chk #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 32,
    localparam int CW      = $clog2(DEPTH) + 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                stop,
    input logic                pace,
    input logic [SAMPLE_W-1:0] dac0_data,
    input logic                dac0_strb,
    input logic [SAMPLE_W-1:0] dac1_data,
    input logic                dac1_strb,
    input logic                underrun,
    input logic                active,
    input logic [CW-1:0]       fill,
    input logic                run_wave,
    input logic                run_dual
);

    a_r10_strobe_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (dac0_strb || dac1_strb) |-> ($past(pace) && $past(active)));

    a_r10_hold_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        !dac0_strb |-> $stable(dac0_data));

    a_r10_hold_ch1: assert property (@(posedge clk) disable iff (!rst_n)
        !dac1_strb |-> $stable(dac1_data));

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!dac0_strb && !dac1_strb));

    a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !start) |=> underrun);

    a_r3_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!active && fill == '0));

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    a_r9_wave_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (active && run_wave && !stop) |=> $stable(fill));

    a_r6_single_quiet_ch1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_dual |-> !dac1_strb);

endmodule

bind aout_seq aout_seq_chk #(
    .SAMPLE_W (SAMPLE_W),
    .DEPTH    (DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .pace      (pace),
    .dac0_data (dac0_data),
    .dac0_strb (dac0_strb),
    .dac1_data (dac1_data),
    .dac1_strb (dac1_strb),
    .underrun  (underrun),
    .active    (active),
    .fill      (fill),
    .run_wave  (run_wave),
    .run_dual  (run_dual)
);

// File: tb/sim_aout_seq.sv
`timescale 1ns/1ps
module sim_aout_seq;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wave = 1'b0;
    logic        cfg_dual = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        pace = 1'b0;
    logic [15:0] dac0_data;
    logic        dac0_strb;
    logic [15:0] dac1_data;
    logic        dac1_strb;
    logic        underrun;
    logic        active;

    int total = 0;
    int bad = 0;
    string req = "R10";

    always #2 clk = !clk;

    aout_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wave(cfg_wave), .cfg_dual(cfg_dual),
        .start(start), .stop(stop), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .pace(pace), .dac0_data(dac0_data),
        .dac0_strb(dac0_strb), .dac1_data(dac1_data), .dac1_strb(dac1_strb),
        .underrun(underrun), .active(active)
    );

    // Behavioural reference model.
    int          q[$];
    int          idx;
    bit          m_act, m_wave, m_dual, m_par, m_und, m_s0, m_s1, started;
    logic [15:0] m_d0, m_d1;

    function automatic bit m_ready();
        return !stop && (!m_act || !m_wave) && (q.size() <= DEPTH - 2);
    endfunction

    always @(posedge clk) begin
        bit acc;
        int smp;
        started = 1'b1;
        if (!rst_n) begin
            q.delete(); idx = 0;
            m_act = 0; m_wave = 0; m_dual = 0; m_par = 0; m_und = 0;
            m_s0 = 0; m_s1 = 0; m_d0 = 16'h8000; m_d1 = 16'h8000;
        end else begin
            acc = wr_valid && m_ready();
            m_s0 = 0; m_s1 = 0;
            if (stop) begin
                m_act = 0; m_par = 0; q.delete(); idx = 0;
            end else begin
                if (m_act && pace) begin
                    if (q.size() == 0) begin
                        m_und = 1;
                    end else begin
                        if (m_wave) begin
                            smp = q[idx];
                            idx = (idx + 1 == q.size()) ? 0 : idx + 1;
                        end else begin
                            smp = q.pop_front();
                        end
                        if (m_dual && m_par) begin m_d1 = 16'(smp); m_s1 = 1; end
                        else begin m_d0 = 16'(smp); m_s0 = 1; end
                        m_par = !m_par;
                    end
                end
                if (acc) begin
                    q.push_back(int'(wr_data[15:0]));
                    q.push_back(int'(wr_data[31:16]));
                end
                if (start && !m_act) begin
                    m_act = 1; m_par = 0; m_und = 0; idx = 0;
                    m_wave = cfg_wave; m_dual = cfg_dual;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the edge.
    always @(negedge clk) begin
        #1;
        if (started) begin
            chk(req, "dac0_data", dac0_data, m_d0);
            chk(req, "dac0_strb", dac0_strb, m_s0);
            chk(req, "dac1_data", dac1_data, m_d1);
            chk(req, "dac1_strb", dac1_strb, m_s1);
            chk("R7", "underrun", underrun, m_und);
            chk("R3", "active", active, m_act);
            chk("R2", "wr_ready", wr_ready, m_ready());
        end
    end

    task automatic put(input logic [31:0] w);
        @(negedge clk); wr_valid = 1; wr_data = w;
        @(negedge clk); wr_valid = 0; #1;
    endtask

    task automatic tick();
        @(negedge clk); pace = 1;
        @(negedge clk); pace = 0; #1;
    endtask

    task automatic go(input bit wave, input bit dual);
        @(negedge clk); cfg_wave = wave; cfg_dual = dual; start = 1;
        @(negedge clk); start = 0; #1;
    endtask

    task automatic halt();
        @(negedge clk); stop = 1;
        @(negedge clk); stop = 0; #1;
    endtask

    initial begin
        #80000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; #1;
        // R10: reset state
        chk("R10", "reset dac0", dac0_data, 16'h8000);
        chk("R10", "reset dac1", dac1_data, 16'h8000);

        // R1 R5 R7: dual streamed
        req = "R5";
        put(32'h2222_1111); put(32'h4444_3333);
        go(0, 1);
        tick(); chk("R1", "first sample even half on ch0", dac0_data, 16'h1111);
        chk("R10", "strobe ch0", dac0_strb, 1);
        tick(); chk("R5", "odd sample on ch1", dac1_data, 16'h2222);
        tick(); tick(); chk("R5", "ch1 fourth", dac1_data, 16'h4444);
        req = "R7";
        tick(); chk("R7", "underrun on empty", underrun, 1);
        chk("R7", "no strobe on empty", dac0_strb | dac1_strb, 0);
        tick(); tick();
        put(32'h6666_5555); tick();
        chk("R7", "ch0 after refill", dac0_data, 16'h5555);
        chk("R7", "underrun still set", underrun, 1);

        // R3: stop
        req = "R3";
        halt(); chk("R3", "active after stop", active, 0);

        // R4: idle pace ignored
        req = "R4";
        put(32'hBBBB_AAAA); tick(); tick();
        chk("R4", "no strobe idle", dac0_strb, 0);
        req = "R6";
        go(0, 0);
        chk("R7", "underrun cleared by start", underrun, 0);
        tick(); chk("R4", "idle ticks kept data", dac0_data, 16'hAAAA);
        tick(); chk("R6", "single all on ch0", dac0_data, 16'hBBBB);
        chk("R6", "ch1 silent", dac1_strb, 0);
        halt();

        // R2: fill to full
        req = "R2";
        for (int i = 0; i < DEPTH/2 + 1; i++) put(32'h0100_0000 * i + 32'h0000_0010 + i);
        chk("R2", "ready low when full", wr_ready, 0);
        go(0, 0); tick(); tick();
        chk("R2", "ready back after two takes", wr_ready, 1);
        halt();

        // R8 R9: waveform replay
        req = "R8";
        put(32'h0002_0001); put(32'h0004_0003);
        go(1, 0);
        for (int i = 0; i < 4; i++) tick();
        tick(); chk("R8", "wrap to first", dac0_data, 16'h0001);
        req = "R9";
        chk("R9", "ready low in replay", wr_ready, 0);
        put(32'h0F0F_0E0E);
        tick(); chk("R9", "refused word absent", dac0_data, 16'h0002);
        for (int i = 0; i < 9; i++) tick();
        halt();

        // R11: config changes mid-run ignored; R8 dual replay
        req = "R11";
        put(32'h00B0_00A0);
        go(1, 1);
        @(negedge clk); cfg_dual = 0; cfg_wave = 0;
        tick(); tick();
        chk("R11", "ch1 still used", dac1_data, 16'h00B0);
        tick(); chk("R11", "still replaying", dac0_data, 16'h00A0);
        chk("R11", "no underrun", underrun, 0);
        halt();

        // R3: stop and start together
        req = "R3";
        @(negedge clk); stop = 1; start = 1;
        @(negedge clk); stop = 0; start = 0; #1;
        chk("R3", "stop wins", active, 0);

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule